// File: doc/BRIEF.md
# Dual Byte Parity Transceiver

This block is a combinational bus transceiver built from independent byte lanes. Two lanes are present by default. Each lane links an A-side byte to a B-side byte. A direction input picks which side is the source. The lane either generates a parity bit for outgoing data or checks parity on incoming data. An active-low enable releases all of the lane's pins, and a sense input selects odd or even parity.

The chip-level pads are tri-state. Inside the core, every pad is modelled as three signals: an input value, an output value and a per-pin drive enable. The pad ring turns these into real tri-state buffers.

The parity pin is shared by both directions. When the lane transmits, the pin is an output carrying the generated bit. When the lane receives, the pin is an input that feeds the checker. The active-low error flag is driven only while the lane receives. There is no clock and no storage, so every output follows its inputs within the same cycle.

Top module: `xcvr_dual`

## Requirements
- R1: With the enable low and direction high (transmit), `b_out` equals `a_in`, every `b_oe` bit is 1 and every `a_oe` bit is 0.
- R2: With the enable low and direction low (receive), `a_out` equals `b_in`, every `a_oe` bit is 1 and every `b_oe` bit is 0.
- R3: With the enable high, all of the lane's drive enables (`a_oe`, `b_oe`, `par_oe`, `err_oe`) are 0, whatever the other inputs are.
- R4: In transmit, `par_oe` is 1. `par_out` is set so that the count of ones over the eight A bits plus the parity bit is odd when the sense input is 1 and even when it is 0. For example, with even sense and five A bits set, `par_out` is 1.
- R5: In receive, `par_oe` is 0 and `err_oe` is 1. `err_n` is 1 when the ones count of the eight B bits plus `par_in` matches the selected sense, and 0 otherwise. For example, with odd sense, `par_in` = 1 and three B bits set, `err_n` is 0.
- R6: In transmit, `err_oe` is 0, so the error flag is released.
- R7: An output whose drive enable is 0 carries a fixed idle value: data and parity outputs read 0 and `err_n` reads 1.
- R8: The lanes are independent. The direction, enable, sense and data of one lane never change the outputs of another lane.
- R9: All outputs respond combinationally, so a new input pattern is reflected at the outputs before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir | input | NUM_SEC | Per-lane direction: 1 sends A to B, 0 sends B to A |
| oe_n | input | NUM_SEC | Per-lane active-low enable; 1 releases every pin of the lane |
| odd_sel | input | NUM_SEC | Per-lane parity sense: 1 odd, 0 even |
| a_in | input | NUM_SEC*DATA_W | Value seen on the A-side pins |
| a_out | output | NUM_SEC*DATA_W | Value driven onto the A-side pins |
| a_oe | output | NUM_SEC*DATA_W | Per-pin drive enable for the A side |
| b_in | input | NUM_SEC*DATA_W | Value seen on the B-side pins |
| b_out | output | NUM_SEC*DATA_W | Value driven onto the B-side pins |
| b_oe | output | NUM_SEC*DATA_W | Per-pin drive enable for the B side |
| par_in | input | NUM_SEC | Value seen on each lane's parity pin |
| par_out | output | NUM_SEC | Generated parity bit driven in transmit |
| par_oe | output | NUM_SEC | Drive enable for each lane's parity pin |
| err_n | output | NUM_SEC | Active-low parity error flag per lane |
| err_oe | output | NUM_SEC | Drive enable for each lane's error flag |

## Verification
Every result of this block is due zero cycles after its stimulus. Outputs, drive enables, generated parity and the error flag all settle in the same cycle as the inputs that cause them. The bench applies each new pattern just after a rising edge and samples every lane at the following falling edge, half a period later. This lets the combinational paths settle and keeps any check from being taken on the next edge. While one lane is swept through all of its data, direction, enable, sense and parity-input values, the other lane receives a different, changing setting and is checked against its own expected outputs at the same sampling point.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_TX  = 2'd1,
        MODE_RX  = 2'd2
    } lane_mode_e;

    function automatic lane_mode_e decode_mode(input logic dir_i, input logic oe_n_i);
        if (oe_n_i) begin
            return MODE_OFF;
        end
        return dir_i ? MODE_TX : MODE_RX;
    endfunction

endpackage

// File: rtl/xcvr_parity_fold.sv
module xcvr_parity_fold #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bits_i,
    input  logic             seed_i,
    output logic             fold_o
);
    logic [WIDTH:0] chain;

    assign chain[0] = seed_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fold
        assign chain[i+1] = chain[i] ^ bits_i[i];
    end

    assign fold_o = chain[WIDTH];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             dir_i,
    input  logic             oe_n_i,
    input  logic             odd_i,
    input  logic [WIDTH-1:0] a_in_i,
    input  logic [WIDTH-1:0] b_in_i,
    input  logic             par_in_i,
    output logic [WIDTH-1:0] a_out_o,
    output logic [WIDTH-1:0] a_oe_o,
    output logic [WIDTH-1:0] b_out_o,
    output logic [WIDTH-1:0] b_oe_o,
    output logic             par_out_o,
    output logic             par_oe_o,
    output logic             err_n_o,
    output logic             err_oe_o
);
    typedef struct packed {
        logic [WIDTH-1:0] a_val;
        logic [WIDTH-1:0] a_en;
        logic [WIDTH-1:0] b_val;
        logic [WIDTH-1:0] b_en;
        logic             p_val;
        logic             p_en;
        logic             e_val;
        logic             e_en;
    } lane_drv_t;

    lane_mode_e mode_d;
    lane_drv_t  drv_d;
    logic       tx_par;
    logic       rx_sum;

    // Seeding with the sense bit yields the parity bit that completes the sense.
    xcvr_parity_fold #(.WIDTH(WIDTH)) u_tx_fold (
        .bits_i (a_in_i),
        .seed_i (odd_i),
        .fold_o (tx_par)
    );

    // Ones count parity of B data plus the received parity bit.
    xcvr_parity_fold #(.WIDTH(WIDTH)) u_rx_fold (
        .bits_i (b_in_i),
        .seed_i (par_in_i),
        .fold_o (rx_sum)
    );

    always_comb begin
        mode_d      = decode_mode(dir_i, oe_n_i);
        drv_d       = '0;
        drv_d.e_val = 1'b1;
        case (mode_d)
            MODE_TX: begin
                drv_d.b_val = a_in_i;
                drv_d.b_en  = '1;
                drv_d.p_val = tx_par;
                drv_d.p_en  = 1'b1;
            end
            MODE_RX: begin
                drv_d.a_val = b_in_i;
                drv_d.a_en  = '1;
                drv_d.e_val = ~(rx_sum ^ odd_i);
                drv_d.e_en  = 1'b1;
            end
            default: ;
        endcase
    end

    assign a_out_o   = drv_d.a_val;
    assign a_oe_o    = drv_d.a_en;
    assign b_out_o   = drv_d.b_val;
    assign b_oe_o    = drv_d.b_en;
    assign par_out_o = drv_d.p_val;
    assign par_oe_o  = drv_d.p_en;
    assign err_n_o   = drv_d.e_val;
    assign err_oe_o  = drv_d.e_en;

    always_comb begin
        // R2
        no_contention_chk: assert ((a_oe_o & b_oe_o) == '0);
        if (oe_n_i) begin
            // R3
            release_chk: assert (a_oe_o == '0 && b_oe_o == '0 && !par_oe_o && !err_oe_o);
        end
        if (!oe_n_i && dir_i) begin
            // R1
            tx_copy_chk: assert (b_out_o == a_in_i && b_oe_o == '1 && !err_oe_o);
            // R4
            tx_parity_chk: assert (^{a_in_i, par_out_o} == odd_i);
        end
        if (!oe_n_i && !dir_i) begin
            // R5
            rx_check_chk: assert (err_n_o == (^{b_in_i, par_in_i} == odd_i) && !par_oe_o);
        end
    end
endmodule

// File: rtl/xcvr_dual.sv
module xcvr_dual #(
    parameter int DATA_W  = 8,
    parameter int NUM_SEC = 2
) (
    input  logic [NUM_SEC-1:0]        dir,
    input  logic [NUM_SEC-1:0]        oe_n,
    input  logic [NUM_SEC-1:0]        odd_sel,
    input  logic [NUM_SEC*DATA_W-1:0] a_in,
    output logic [NUM_SEC*DATA_W-1:0] a_out,
    output logic [NUM_SEC*DATA_W-1:0] a_oe,
    input  logic [NUM_SEC*DATA_W-1:0] b_in,
    output logic [NUM_SEC*DATA_W-1:0] b_out,
    output logic [NUM_SEC*DATA_W-1:0] b_oe,
    input  logic [NUM_SEC-1:0]        par_in,
    output logic [NUM_SEC-1:0]        par_out,
    output logic [NUM_SEC-1:0]        par_oe,
    output logic [NUM_SEC-1:0]        err_n,
    output logic [NUM_SEC-1:0]        err_oe
);
    localparam int BUS_W = NUM_SEC * DATA_W;

    logic [BUS_W-1:0] a_oe_all;
    logic [BUS_W-1:0] b_oe_all;

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_lane
        xcvr_lane #(.WIDTH(DATA_W)) u_lane (
            .dir_i     (dir[s]),
            .oe_n_i    (oe_n[s]),
            .odd_i     (odd_sel[s]),
            .a_in_i    (a_in[s*DATA_W +: DATA_W]),
            .b_in_i    (b_in[s*DATA_W +: DATA_W]),
            .par_in_i  (par_in[s]),
            .a_out_o   (a_out[s*DATA_W +: DATA_W]),
            .a_oe_o    (a_oe_all[s*DATA_W +: DATA_W]),
            .b_out_o   (b_out[s*DATA_W +: DATA_W]),
            .b_oe_o    (b_oe_all[s*DATA_W +: DATA_W]),
            .par_out_o (par_out[s]),
            .par_oe_o  (par_oe[s]),
            .err_n_o   (err_n[s]),
            .err_oe_o  (err_oe[s])
        );
    end

    assign a_oe = a_oe_all;
    assign b_oe = b_oe_all;

    always_comb begin
        // R2
        bus_contention_chk: assert ((a_oe_all & b_oe_all) == '0);
    end
endmodule

// File: tb/xcvr_dual_test.sv
`timescale 1ns/1ps
module xcvr_dual_test;
    localparam int W  = 8;
    localparam int NS = 2;
    localparam int BW = W * NS;
    localparam int VW = 4 * W + 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [NS-1:0] dir, oe_n, odd_sel, par_in, par_out, par_oe, err_n, err_oe;
    logic [BW-1:0] a_in, a_out, a_oe, b_in, b_out, b_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    xcvr_dual #(.DATA_W(W), .NUM_SEC(NS)) uut (
        .dir(dir), .oe_n(oe_n), .odd_sel(odd_sel),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .err_n(err_n), .err_oe(err_oe)
    );

    // Expected lane outputs: {a_out, a_oe, b_out, b_oe, par_out, par_oe, err_n, err_oe}
    function automatic logic [VW-1:0] model(input logic d, input logic en_n, input logic odd,
                                            input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic p);
        logic [W-1:0] ao, aoe, bo, boe;
        logic po, poe, en, eoe;
        ao = '0; aoe = '0; bo = '0; boe = '0;
        po = 1'b0; poe = 1'b0; en = 1'b1; eoe = 1'b0;
        if (!en_n) begin
            if (d) begin
                bo  = a;
                boe = '1;
                po  = (($countones(a) % 2) == 1) ^ odd;
                poe = 1'b1;
            end else begin
                ao  = b;
                aoe = '1;
                en  = ((($countones(b) + int'(p)) % 2) == 1) == odd;
                eoe = 1'b1;
            end
        end
        return {ao, aoe, bo, boe, po, poe, en, eoe};
    endfunction

    function automatic logic [VW-1:0] observe(input int s);
        return {a_out[s*W +: W], a_oe[s*W +: W], b_out[s*W +: W], b_oe[s*W +: W],
                par_out[s], par_oe[s], err_n[s], err_oe[s]};
    endfunction

    task automatic compare(input string tag, input int s, input logic [VW-1:0] got,
                           input logic [VW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s lane %0d: actual %h expected %h", tag, s, got, exp);
        end
    endtask

    task automatic check_lane(input int s, input bit other);
        logic [VW-1:0] exp, got, m_data, m_par, m_err;
        string t_data, t_par, t_err;
        exp = model(dir[s], oe_n[s], odd_sel[s], a_in[s*W +: W], b_in[s*W +: W], par_in[s]);
        got = observe(s);
        if (other) begin
            // R8: the neighbour lane follows only its own inputs
            compare("R8", s, got, exp);
            return;
        end
        m_data = {{(4*W){1'b1}}, 4'b0000};
        m_par  = {{(4*W){1'b0}}, 4'b1100};
        m_err  = {{(4*W){1'b0}}, 4'b0011};
        if (oe_n[s]) begin
            t_data = "R3 R7"; t_par = "R3 R7"; t_err = "R3 R7";
        end else if (dir[s]) begin
            t_data = "R1 R7 R9"; t_par = "R4"; t_err = "R6 R7";
        end else begin
            t_data = "R2 R7 R9"; t_par = "R5 R7"; t_err = "R5";
        end
        compare(t_data, s, got & m_data, exp & m_data);
        compare(t_par,  s, got & m_par,  exp & m_par);
        compare(t_err,  s, got & m_err,  exp & m_err);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        dir = '0; oe_n = '1; odd_sel = '0; par_in = '0;
        a_in = '0; b_in = '0;
        @(negedge clk);
        // R3: released state with every lane disabled
        for (int s = 0; s < NS; s++) check_lane(s, 1'b0);

        // Directed examples from the requirements
        @(posedge clk);
        oe_n[0] = 1'b0; dir[0] = 1'b1; odd_sel[0] = 1'b0; a_in[W-1:0] = 8'h1F;
        @(negedge clk);
        n_tests++;
        if (par_out[0] !== 1'b1) begin
            n_fail++;
            $display("FAIL R4 even sense five ones: actual %b expected 1", par_out[0]);
        end
        @(posedge clk);
        dir[0] = 1'b0; odd_sel[0] = 1'b1; par_in[0] = 1'b1; b_in[W-1:0] = 8'h07;
        @(negedge clk);
        n_tests++;
        if (err_n[0] !== 1'b0 || err_oe[0] !== 1'b1) begin
            n_fail++;
            $display("FAIL R5 odd sense three ones: actual %b%b expected 01", err_n[0], err_oe[0]);
        end

        // Exhaustive sweep of one lane while the other runs a contrasting setting
        for (int s = 0; s < NS; s++) begin
            for (int cfg = 0; cfg < 16; cfg++) begin
                for (int d = 0; d < 256; d++) begin
                    @(posedge clk);
                    for (int o = 0; o < NS; o++) begin
                        if (o == s) begin
                            dir[o]        = cfg[0];
                            oe_n[o]       = cfg[1];
                            odd_sel[o]    = cfg[2];
                            par_in[o]     = cfg[3];
                            a_in[o*W +: W] = d[W-1:0];
                            b_in[o*W +: W] = d[W-1:0] ^ 8'h5A;
                        end else begin
                            dir[o]        = ~cfg[0] ^ d[0];
                            oe_n[o]       = d[1] & d[2];
                            odd_sel[o]    = ~cfg[2];
                            par_in[o]     = d[3];
                            a_in[o*W +: W] = ~d[W-1:0];
                            b_in[o*W +: W] = d[W-1:0] + 8'd37;
                        end
                    end
                    @(negedge clk);
                    for (int o = 0; o < NS; o++) check_lane(o, o != s);
                end
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule